// File: doc/BRIEF.md
# Wake-Retaining Configuration Register Bank with Dual Reset

This block is a small bank of byte-wide configuration registers reached through a simple address/write-data/read-data port. It has two synchronous reset inputs. The global reset is used once, at power-up. The bus reset can arrive many times while the system runs. Every register bit belongs to one of two classes: plain bits, which any reset clears, and wake-retained bits, which survive a bus reset whenever wake signalling is armed.

The bank holds a power-management control/status register and a general-purpose event status/enable pair. The power-management register carries the wake arm bit and a sticky wake flag. The event pair drives a single event output. Hardware inputs set the sticky flags. Software clears them by writing a one to the flag's bit.

A four-state reset sequencer chooses between clearing and keeping the wake-retained bits. ST_GLOBAL is entered whenever the global reset is high, and that has priority over everything else. ST_RUN is normal operation. ST_BUS_KEEP and ST_BUS_CLEAR hold the decision taken on the first cycle of a bus reset for as long as that reset stays asserted.

The transitions are:
- ST_GLOBAL or ST_RUN to ST_BUS_KEEP, when the bus reset is asserted and the wake arm bit reads 1.
- ST_GLOBAL or ST_RUN to ST_BUS_CLEAR, when the bus reset is asserted and the wake arm bit reads 0.
- ST_GLOBAL to ST_RUN, when both resets are low.
- ST_BUS_KEEP or ST_BUS_CLEAR to ST_RUN, when the bus reset is released.
- Any state to ST_GLOBAL, when the global reset is high.

On the first cycle of a bus reset the decision uses the wake arm bit as it stood before that reset.

Top module: `wrst_bank`

## Requirements
- R1: While the global reset is high at a clock edge, every register bit returns to 0 at that edge. This includes the retained byte, the wake arm bit and the wake flag, whatever the wake arm bit held before.
- R2: A bus reset taken while the wake arm bit is 0 clears the retained byte (0x80) and the wake flag and arm bits, as well as all plain bits.
- R3: A bus reset taken while the wake arm bit is 1 clears the plain bits: 0x81, 0x88, 0x89 and the power state. The retained byte, the wake arm bit and the wake flag keep their values for every cycle of the reset and afterwards.
- R4: When both resets are high in the same cycle, the global reset wins and all bits are cleared.
- R5: The wake flag is bit 7 at offset 0xA5, which is bit 15 of the power-management register. A one-cycle pulse on `wake_in` sets it. Writing 1 to that bit clears it, and writing 0 leaves it unchanged. A pulse that arrives in the same cycle as a clearing write leaves the flag set.
- R6: Event status bit i at offset 0x88 is set by a pulse on `evt_in[i]`. Writing 1 to bit i clears only that bit.
- R7: `gpe_evt` is 1 exactly when some status bit at 0x88 and the same bit of the enable register at 0x89 are both 1. An event pulse in cycle N therefore raises it from cycle N+1.
- R8: Offsets 0x80, 0x81 and 0x89 are read/write bytes. Offset 0xA4 holds a 2-bit power state in bits 1:0 and reads the rest as 0. Offset 0xA5 holds the wake arm bit in bit 0 (register bit 8), the wake flag in bit 7, and reads 0 elsewhere. `rd_data` is a combinational read of the byte at `addr`.
- R9: Every other offset reads 0, and writes to it change no register.
- R10: While either reset is high, register writes and the `wake_in` and `evt_in` pulses have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| glb_rst | input | 1 | Global power-up reset, synchronous, active high |
| bus_rst | input | 1 | Bus reset, synchronous, active high |
| addr | input | 8 | Byte offset for read and write |
| wr_en | input | 1 | Write strobe for the byte at `addr` |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Read data of the byte at `addr` |
| wake_in | input | 1 | Wake event pulse, sets the wake flag |
| evt_in | input | NEVT | Event pulses, one per status bit |
| gpe_evt | output | 1 | Event output, any enabled status bit set |

## Verification
The hardest case to reach from the ports is a bus reset that finds the wake arm bit set, so that the sequencer enters ST_BUS_KEEP. Reaching it also requires the retained bits to hold recognisable non-zero values. The stimulus first arms wake and loads distinct patterns into the retained and plain bytes. It then asserts the bus reset for several cycles, and during that reset it writes a clearing value and pulses `wake_in` to show that nothing moves. After the reset is released it reads back every offset. A later global reset shows that the same retained values do not survive the power-up path.

// File: rtl/wrst_pkg.sv
package wrst_pkg;

    typedef enum logic [1:0] {
        ST_GLOBAL    = 2'd0,
        ST_RUN       = 2'd1,
        ST_BUS_KEEP  = 2'd2,
        ST_BUS_CLEAR = 2'd3
    } rst_state_e;

    localparam int          BYTE_W      = 8;
    localparam int          PSTATE_W    = 2;
    localparam logic [7:0]  OFS_RETAIN  = 8'h80;
    localparam logic [7:0]  OFS_PLAIN   = 8'h81;
    localparam logic [7:0]  OFS_GPE_STS = 8'h88;
    localparam logic [7:0]  OFS_GPE_EN  = 8'h89;
    localparam logic [7:0]  OFS_PM_LO   = 8'hA4;
    localparam logic [7:0]  OFS_PM_HI   = 8'hA5;
    localparam int          HI_ARM_BIT  = 0;
    localparam int          HI_FLAG_BIT = 7;

endpackage

// File: rtl/wrst_seq.sv
module wrst_seq
    import wrst_pkg::*;
(
    input  logic clk,
    input  logic glb_rst,
    input  logic bus_rst,
    input  logic wake_arm,
    output logic clr_plain,
    output logic clr_retain,
    output logic hold
);

    rst_state_e state_q;
    rst_state_e state_d;
    logic       keep;

    always_ff @(posedge clk) begin
        if (glb_rst) state_q <= ST_GLOBAL;
        else         state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_GLOBAL, ST_RUN: begin
                if (bus_rst) state_d = wake_arm ? ST_BUS_KEEP : ST_BUS_CLEAR;
                else         state_d = ST_RUN;
            end
            ST_BUS_KEEP, ST_BUS_CLEAR: begin
                if (!bus_rst) state_d = ST_RUN;
            end
            default: state_d = ST_GLOBAL;
        endcase
    end

    // On the first bus-reset cycle the arm bit still holds its pre-reset value.
    always_comb begin
        unique case (state_q)
            ST_GLOBAL, ST_RUN: keep = wake_arm;
            ST_BUS_KEEP:       keep = 1'b1;
            ST_BUS_CLEAR:      keep = 1'b0;
            default:           keep = 1'b0;
        endcase
        hold       = glb_rst | bus_rst;
        clr_plain  = glb_rst | bus_rst;
        clr_retain = glb_rst | (bus_rst & ~keep);
    end

endmodule

// File: rtl/wrst_gpe.sv
module wrst_gpe #(
    parameter int NEVT = 8
) (
    input  logic            clk,
    input  logic            clr,
    input  logic            hold,
    input  logic            wr_sts,
    input  logic            wr_en_reg,
    input  logic [NEVT-1:0] wdata,
    input  logic [NEVT-1:0] evt_in,
    output logic [NEVT-1:0] sts_q,
    output logic [NEVT-1:0] en_q,
    output logic            evt_out
);

    logic [NEVT-1:0] hit;

    for (genvar i = 0; i < NEVT; i++) begin : g_cell
        always_ff @(posedge clk) begin
            if (clr) begin
                sts_q[i] <= 1'b0;
                en_q[i]  <= 1'b0;
            end else if (!hold) begin
                sts_q[i] <= evt_in[i] | (sts_q[i] & ~(wr_sts & wdata[i]));
                if (wr_en_reg) en_q[i] <= wdata[i];
            end
        end
        assign hit[i] = sts_q[i] & en_q[i];
    end

    assign evt_out = |hit;

endmodule

// File: rtl/wrst_pm.sv
module wrst_pm
    import wrst_pkg::*;
(
    input  logic                clk,
    input  logic                clr_plain,
    input  logic                clr_retain,
    input  logic                hold,
    input  logic                wr_retain,
    input  logic                wr_plain,
    input  logic                wr_pm_lo,
    input  logic                wr_pm_hi,
    input  logic [BYTE_W-1:0]   wdata,
    input  logic                wake_in,
    output logic [BYTE_W-1:0]   retain_q,
    output logic [BYTE_W-1:0]   plain_q,
    output logic [PSTATE_W-1:0] pstate_q,
    output logic                wake_arm_q,
    output logic                wake_flag_q
);

    // Plain class
    always_ff @(posedge clk) begin
        if (clr_plain) begin
            plain_q  <= '0;
            pstate_q <= '0;
        end else if (!hold) begin
            if (wr_plain) plain_q  <= wdata;
            if (wr_pm_lo) pstate_q <= wdata[PSTATE_W-1:0];
        end
    end

    // Wake-retained class
    always_ff @(posedge clk) begin
        if (clr_retain) begin
            retain_q    <= '0;
            wake_arm_q  <= 1'b0;
            wake_flag_q <= 1'b0;
        end else if (!hold) begin
            if (wr_retain) retain_q   <= wdata;
            if (wr_pm_hi)  wake_arm_q <= wdata[HI_ARM_BIT];
            wake_flag_q <= wake_in | (wake_flag_q & ~(wr_pm_hi & wdata[HI_FLAG_BIT]));
        end
    end

endmodule

// File: rtl/wrst_bank.sv
module wrst_bank
    import wrst_pkg::*;
#(
    parameter int NEVT = 8
) (
    input  logic            clk,
    input  logic            glb_rst,
    input  logic            bus_rst,
    input  logic [7:0]      addr,
    input  logic            wr_en,
    input  logic [7:0]      wr_data,
    output logic [7:0]      rd_data,
    input  logic            wake_in,
    input  logic [NEVT-1:0] evt_in,
    output logic            gpe_evt
);

    logic                clr_plain, clr_retain, hold;
    logic [BYTE_W-1:0]   retain_q, plain_q;
    logic [PSTATE_W-1:0] pstate_q;
    logic                wake_arm_q, wake_flag_q;
    logic [NEVT-1:0]     gpe_sts_q, gpe_en_q;
    logic [7:0]          sts_byte, en_byte;

    wrst_seq u_seq (
        .clk        (clk),
        .glb_rst    (glb_rst),
        .bus_rst    (bus_rst),
        .wake_arm   (wake_arm_q),
        .clr_plain  (clr_plain),
        .clr_retain (clr_retain),
        .hold       (hold)
    );

    wrst_pm u_pm (
        .clk         (clk),
        .clr_plain   (clr_plain),
        .clr_retain  (clr_retain),
        .hold        (hold),
        .wr_retain   (wr_en && addr == OFS_RETAIN),
        .wr_plain    (wr_en && addr == OFS_PLAIN),
        .wr_pm_lo    (wr_en && addr == OFS_PM_LO),
        .wr_pm_hi    (wr_en && addr == OFS_PM_HI),
        .wdata       (wr_data),
        .wake_in     (wake_in),
        .retain_q    (retain_q),
        .plain_q     (plain_q),
        .pstate_q    (pstate_q),
        .wake_arm_q  (wake_arm_q),
        .wake_flag_q (wake_flag_q)
    );

    wrst_gpe #(.NEVT(NEVT)) u_gpe (
        .clk       (clk),
        .clr       (clr_plain),
        .hold      (hold),
        .wr_sts    (wr_en && addr == OFS_GPE_STS),
        .wr_en_reg (wr_en && addr == OFS_GPE_EN),
        .wdata     (wr_data[NEVT-1:0]),
        .evt_in    (evt_in),
        .sts_q     (gpe_sts_q),
        .en_q      (gpe_en_q),
        .evt_out   (gpe_evt)
    );

    always_comb begin
        sts_byte = '0;
        en_byte  = '0;
        sts_byte[NEVT-1:0] = gpe_sts_q;
        en_byte[NEVT-1:0]  = gpe_en_q;
        rd_data = '0;
        case (addr)
            OFS_RETAIN:  rd_data = retain_q;
            OFS_PLAIN:   rd_data = plain_q;
            OFS_GPE_STS: rd_data = sts_byte;
            OFS_GPE_EN:  rd_data = en_byte;
            OFS_PM_LO:   rd_data[PSTATE_W-1:0] = pstate_q;
            OFS_PM_HI: begin
                rd_data[HI_ARM_BIT]  = wake_arm_q;
                rd_data[HI_FLAG_BIT] = wake_flag_q;
            end
            default:     rd_data = '0;
        endcase
    end

endmodule

// File: rtl/wrst_chk.sv
module wrst_chk
    import wrst_pkg::*;
#(
    parameter int NEVT = 8
) (
    input logic                clk,
    input logic                glb_rst,
    input logic                bus_rst,
    input logic [7:0]          addr,
    input logic                wr_en,
    input logic [7:0]          wr_data,
    input logic                wake_in,
    input logic [NEVT-1:0]     evt_in,
    input logic                gpe_evt,
    input logic [BYTE_W-1:0]   retain_q,
    input logic [BYTE_W-1:0]   plain_q,
    input logic [PSTATE_W-1:0] pstate_q,
    input logic                wake_arm_q,
    input logic                wake_flag_q,
    input logic [NEVT-1:0]     gpe_sts_q,
    input logic [NEVT-1:0]     gpe_en_q
);

    logic seen_glb = 1'b0;
    always_ff @(posedge clk) if (glb_rst) seen_glb <= 1'b1;

    p_glb_clear_r1: assert property (@(posedge clk) disable iff (!seen_glb)
        glb_rst |=> (retain_q == '0 && plain_q == '0 && pstate_q == '0 &&
                     !wake_arm_q && !wake_flag_q && gpe_sts_q == '0 && gpe_en_q == '0));

    p_bus_clear_r2: assert property (@(posedge clk) disable iff (!seen_glb)
        (bus_rst && !glb_rst && !wake_arm_q) |=> (retain_q == '0 && !wake_arm_q && !wake_flag_q));

    p_bus_keep_r3: assert property (@(posedge clk) disable iff (!seen_glb)
        (bus_rst && !glb_rst && wake_arm_q) |=>
            (wake_arm_q && $stable(retain_q) && $stable(wake_flag_q)));

    p_bus_plain_r3: assert property (@(posedge clk) disable iff (!seen_glb)
        bus_rst |=> (plain_q == '0 && pstate_q == '0 && gpe_sts_q == '0 && gpe_en_q == '0));

    p_wake_set_r5: assert property (@(posedge clk) disable iff (!seen_glb)
        (wake_in && !glb_rst && !bus_rst) |=> wake_flag_q);

    p_w1c_zero_r5: assert property (@(posedge clk) disable iff (!seen_glb)
        (wake_flag_q && !glb_rst && !bus_rst && wr_en && addr == OFS_PM_HI && !wr_data[HI_FLAG_BIT])
            |=> wake_flag_q);

    p_evt_out_r7: assert property (@(posedge clk) disable iff (!seen_glb)
        (!glb_rst && !bus_rst && (evt_in & gpe_en_q) != '0 && !(wr_en && addr == OFS_GPE_EN))
            |=> gpe_evt);

endmodule

bind wrst_bank wrst_chk #(.NEVT(NEVT)) u_chk (
    .clk         (clk),
    .glb_rst     (glb_rst),
    .bus_rst     (bus_rst),
    .addr        (addr),
    .wr_en       (wr_en),
    .wr_data     (wr_data),
    .wake_in     (wake_in),
    .evt_in      (evt_in),
    .gpe_evt     (gpe_evt),
    .retain_q    (retain_q),
    .plain_q     (plain_q),
    .pstate_q    (pstate_q),
    .wake_arm_q  (wake_arm_q),
    .wake_flag_q (wake_flag_q),
    .gpe_sts_q   (gpe_sts_q),
    .gpe_en_q    (gpe_en_q)
);

// File: tb/tb_wrst_bank.sv
`timescale 1ns/1ps
module tb_wrst_bank;

    localparam int NEVT = 8;

    logic            clk = 1'b0;
    logic            glb_rst = 1'b1;
    logic            bus_rst = 1'b0;
    logic [7:0]      addr = '0;
    logic            wr_en = 1'b0;
    logic [7:0]      wr_data = '0;
    logic [7:0]      rd_data;
    logic            wake_in = 1'b0;
    logic [NEVT-1:0] evt_in = '0;
    logic            gpe_evt;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #4 clk = ~clk;

    wrst_bank #(.NEVT(NEVT)) dut (
        .clk(clk), .glb_rst(glb_rst), .bus_rst(bus_rst), .addr(addr),
        .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
        .wake_in(wake_in), .evt_in(evt_in), .gpe_evt(gpe_evt)
    );

    task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
        n_cmp++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %02h expected %02h", req, got, exp);
        end
    endtask

    task automatic rd(input string req, input logic [7:0] a, input logic [7:0] exp);
        @(negedge clk);
        addr = a;
        #1;
        check(req, rd_data, exp);
    endtask

    task automatic evt_chk(input string req, input logic exp);
        #1;
        check(req, {7'd0, gpe_evt}, {7'd0, exp});
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        addr = a; wr_data = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic pulse_wake();
        @(negedge clk); wake_in = 1'b1;
        @(negedge clk); wake_in = 1'b0;
    endtask

    task automatic pulse_evt(input logic [NEVT-1:0] v);
        @(negedge clk); evt_in = v;
        @(negedge clk); evt_in = '0;
    endtask

    task automatic do_glb();
        @(negedge clk); glb_rst = 1'b1;
        @(negedge clk); glb_rst = 1'b0;
    endtask

    task automatic t_reset_state();
        rd("R1", 8'h80, 8'h00); rd("R1", 8'h81, 8'h00); rd("R1", 8'h88, 8'h00);
        rd("R1", 8'h89, 8'h00); rd("R1", 8'hA4, 8'h00); rd("R1", 8'hA5, 8'h00);
        evt_chk("R1", 1'b0);
    endtask

    task automatic t_readwrite();
        wr(8'h80, 8'hA5); rd("R8", 8'h80, 8'hA5);
        wr(8'h81, 8'h3C); rd("R8", 8'h81, 8'h3C);
        wr(8'h89, 8'h0F); rd("R8", 8'h89, 8'h0F);
        wr(8'hA4, 8'hFF); rd("R8", 8'hA4, 8'h03);
        wr(8'hA5, 8'hFF); rd("R8", 8'hA5, 8'h01);
        wr(8'hA5, 8'h00); rd("R8", 8'hA5, 8'h00);
    endtask

    task automatic t_unimpl();
        wr(8'h82, 8'hFF); wr(8'h8A, 8'hFF); wr(8'hA6, 8'hFF); wr(8'h00, 8'hFF); wr(8'hFF, 8'hFF);
        rd("R9", 8'h82, 8'h00); rd("R9", 8'h8A, 8'h00); rd("R9", 8'hA6, 8'h00);
        rd("R9", 8'h00, 8'h00); rd("R9", 8'hFF, 8'h00);
        rd("R9", 8'h80, 8'hA5); rd("R9", 8'h81, 8'h3C); rd("R9", 8'h89, 8'h0F);
        rd("R9", 8'hA4, 8'h03); rd("R9", 8'hA5, 8'h00); rd("R9", 8'h88, 8'h00);
    endtask

    task automatic t_wake_flag();
        pulse_wake();        rd("R5", 8'hA5, 8'h80);
        wr(8'hA5, 8'h00);    rd("R5", 8'hA5, 8'h80);
        wr(8'hA5, 8'h80);    rd("R5", 8'hA5, 8'h00);
        pulse_wake();
        @(negedge clk);      // set and clear collide: set wins
        addr = 8'hA5; wr_data = 8'h80; wr_en = 1'b1; wake_in = 1'b1;
        @(negedge clk);
        wr_en = 1'b0; wake_in = 1'b0;
        rd("R5", 8'hA5, 8'h80);
        wr(8'hA5, 8'h80);    rd("R5", 8'hA5, 8'h00);
    endtask

    task automatic t_events();
        pulse_evt(8'h30); evt_chk("R7", 1'b0); rd("R6", 8'h88, 8'h30);
        pulse_evt(8'h01); evt_chk("R7", 1'b1); rd("R6", 8'h88, 8'h31);
        wr(8'h88, 8'h01); evt_chk("R7", 1'b0); rd("R6", 8'h88, 8'h30);
        wr(8'h89, 8'h20); evt_chk("R7", 1'b1);
        wr(8'h88, 8'h10); evt_chk("R7", 1'b1); rd("R6", 8'h88, 8'h20);
        wr(8'h88, 8'h20); evt_chk("R7", 1'b0); rd("R6", 8'h88, 8'h00);
    endtask

    task automatic t_bus_clear();
        wr(8'h80, 8'h5A); wr(8'hA5, 8'h00); pulse_wake(); wr(8'h81, 8'h11);
        rd("R2", 8'hA5, 8'h80);
        @(negedge clk); bus_rst = 1'b1;
        repeat (3) @(negedge clk);
        bus_rst = 1'b0;
        rd("R2", 8'h80, 8'h00); rd("R2", 8'hA5, 8'h00); rd("R2", 8'h81, 8'h00);
    endtask

    task automatic t_bus_keep();
        wr(8'h80, 8'hC3); wr(8'hA5, 8'h01); pulse_wake(); wr(8'h81, 8'h22);
        wr(8'h89, 8'hFF); wr(8'hA4, 8'h02); pulse_evt(8'h04);
        evt_chk("R7", 1'b1);
        rd("R3", 8'hA5, 8'h81);
        @(negedge clk); bus_rst = 1'b1;
        wr(8'hA5, 8'h80);                 // R10: write during reset ignored
        wr(8'h80, 8'h00);
        rd("R3", 8'h80, 8'hC3);
        rd("R3", 8'hA5, 8'h81);
        @(negedge clk); bus_rst = 1'b0;
        rd("R3", 8'h80, 8'hC3); rd("R10", 8'hA5, 8'h81); rd("R3", 8'h81, 8'h00);
        rd("R3", 8'h88, 8'h00); rd("R3", 8'h89, 8'h00); rd("R3", 8'hA4, 8'h00);
        evt_chk("R3", 1'b0);
        wr(8'hA5, 8'h81); rd("R10", 8'hA5, 8'h01);
        @(negedge clk); bus_rst = 1'b1;
        pulse_wake();                     // R10: wake pulse during reset ignored
        pulse_evt(8'hFF);
        @(negedge clk); bus_rst = 1'b0;
        rd("R10", 8'hA5, 8'h01); rd("R10", 8'h88, 8'h00); rd("R10", 8'h80, 8'hC3);
    endtask

    task automatic t_glb_kills_retained();
        pulse_wake(); rd("R1", 8'hA5, 8'h81);
        do_glb();
        rd("R1", 8'h80, 8'h00); rd("R1", 8'hA5, 8'h00);
    endtask

    task automatic t_both_resets();
        wr(8'h80, 8'h77); wr(8'hA5, 8'h01); pulse_wake(); wr(8'h81, 8'h44);
        @(negedge clk); glb_rst = 1'b1; bus_rst = 1'b1;
        @(negedge clk); glb_rst = 1'b0;
        @(negedge clk); bus_rst = 1'b0;
        rd("R4", 8'h80, 8'h00); rd("R4", 8'hA5, 8'h00); rd("R4", 8'h81, 8'h00);
    endtask

    initial begin
        repeat (2) @(negedge clk);
        glb_rst = 1'b0;
        t_reset_state();
        t_readwrite();
        t_unimpl();
        t_wake_flag();
        t_events();
        t_bus_clear();
        t_bus_keep();
        t_glb_kills_retained();
        t_both_resets();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule